// File: doc/BRIEF.md
# Four-Channel Periodic Tick Timer

This block holds four independent 16-bit down-counting timer channels behind a byte-wide register port. Each channel has a 16-bit reload value, a down-counter, an enable bit, an expiry flag and an interrupt enable. A single module enable gates every channel. The counters step once per cycle in which the `tick` input is high, so the time base comes from outside the block. When a counter steps below zero it sets its flag and starts again from its reload value. The interrupt output is the OR of the flags that have their interrupt enable set.

Software programs the reload values, switches channels on and clears flags through byte writes. The read data path is combinational: `bus_rdata` shows the register at `bus_addr` in the same cycle. A write takes effect at the clock edge on which `bus_wr` is high. Software can restart any running channel at once by writing a one to that channel's bit of a write-only restart strobe register.

Register map (byte offsets), with channel i on bit i of each per-channel field:

| Offset | Contents |
|---|---|
| 0x00 | bit 7 is the module enable; bits 6:0 are reserved |
| 0x01 | restart strobes in bits 3:0 (write one) |
| 0x02 | channel enables in bits 3:0 |
| 0x04 | interrupt enables in bits 3:0 |
| 0x05 | expiry flags in bits 3:0 (write one to clear) |
| 0x08+2i, 0x09+2i | reload value of channel i: upper byte, then lower byte |
| 0x10+2i, 0x11+2i | counter of channel i: upper byte, then lower byte (read-only) |

Top module: `tick_timer_bank`

## Requirements
- R1: After reset, every register and counter reads as zero at every offset listed, and `irq` is low.
- R2: Writing a one to a channel enable bit at 0x02 that was clear, while bit 7 of 0x00 is set, copies the reload value into the counter at that write's clock edge.
- R3: On each clock edge with `tick` high, the counter of a channel whose enable and module enable are both set drops by one. A counter never changes while its channel or the module is disabled.
- R4: A running channel whose counter is zero when a tick arrives sets its flag (0x05 bit i) and reloads on that edge, so the flag rises every reload+1 ticks.
- R5: Writing a one to bit i of 0x01 copies the reload value into counter i, but only when channel i and the module are both enabled. Otherwise the write, and any zero bit, leaves the counter unchanged. A restart or start in the same cycle as a tick wins, and that tick neither steps the counter nor sets the flag.
- R6: Offset 0x01 always reads zero. Reserved bits (7:4 of 0x02, 0x04 and 0x05, and 6:0 of 0x00) read zero and ignore writes.
- R7: Writing zero to a channel enable bit clears that channel's flag.
- R8: Writing a one to bit i of 0x05 clears flag i. Zero bits leave their flags untouched. A flag that is being set on the same edge stays set.
- R9: `irq` is high exactly when some flag bit and the matching 0x04 bit are both set.
- R10: Writing bit 7 of 0x00 as zero clears all flags and freezes all counters at their current values.
- R11: Setting bit 7 of 0x00 when it was clear reloads every channel whose enable bit is already set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick | input | 1 | Count-enable strobe for all channels |
| bus_wr | input | 1 | Write strobe for the register port |
| bus_addr | input | 5 | Register byte offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr`, combinational |
| irq | output | 1 | Combined interrupt request |

## Verification
The bench builds the block with its default parameters: four channels and 16-bit counters. It keeps most reload values below 16, so expiry, reload and flag races with clears and restarts occur many times within a few thousand cycles. Random writes often land in the same cycle as a tick. This exercises the priority between a start or restart and a counting step, and between flag setting and clearing. Directed sequences cover the freeze and resume of the module enable, and restart writes that a disabled channel must ignore.

// File: rtl/ttb_pkg.sv
package ttb_pkg;
  // byte offsets of the register port
  localparam logic [7:0] OFS_CTRL  = 8'h00;
  localparam logic [7:0] OFS_KICK  = 8'h01;
  localparam logic [7:0] OFS_CHEN  = 8'h02;
  localparam logic [7:0] OFS_IEN   = 8'h04;
  localparam logic [7:0] OFS_FLAG  = 8'h05;
  localparam logic [7:0] OFS_LOAD  = 8'h08;
  localparam logic [7:0] OFS_COUNT = 8'h10;
  localparam int         RUN_BIT   = 7;

  // upper-byte offset of a per-channel 16-bit pair; lower byte follows
  function automatic logic [7:0] pair_hi(input logic [7:0] base, input int ch);
    return base + 8'(2 * ch);
  endfunction

  function automatic logic [7:0] pair_lo(input logic [7:0] base, input int ch);
    return base + 8'(2 * ch + 1);
  endfunction
endpackage

// File: rtl/ttb_channel.sv
module ttb_channel #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             active,
  input  logic             load_evt,
  input  logic             wipe,
  input  logic             w1c,
  input  logic [CNT_W-1:0] load_val,
  output logic [CNT_W-1:0] cnt,
  output logic             flag,
  output logic             expire
);
  // next value of a running counter on a tick
  function automatic logic [CNT_W-1:0] step_down(input logic [CNT_W-1:0] c,
                                                 input logic [CNT_W-1:0] ld);
    return (c == '0) ? ld : c - CNT_W'(1);
  endfunction

  logic counting;
  assign counting = tick & active & ~load_evt;
  assign expire   = counting & (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cnt <= '0;
    else if (load_evt) cnt <= load_val;
    else if (counting) cnt <= step_down(cnt, load_val);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      flag <= 1'b0;
    else if (wipe)   flag <= 1'b0;
    else if (expire) flag <= 1'b1;
    else if (w1c)    flag <= 1'b0;
  end

  assert_count_down_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (counting && cnt != '0) |=> cnt == $past(cnt) - CNT_W'(1));
  assert_frozen_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(counting || load_evt) |=> $stable(cnt));
  assert_reload_on_expire_R4: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> cnt == $past(load_val));
  assert_flag_on_expire_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && !wipe) |=> flag);
  assert_load_copies_R5: assert property (@(posedge clk) disable iff (!rst_n)
    load_evt |=> cnt == $past(load_val));
  assert_wipe_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wipe |=> !flag);
  assert_idle_no_flag_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!active && !flag) |=> !flag);
endmodule

// File: rtl/ttb_regfile.sv
module ttb_regfile
  import ttb_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int CNT_W  = 16,
  parameter int ADDR_W = 5
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    bus_wr,
  input  logic [ADDR_W-1:0]       bus_addr,
  input  logic [7:0]              bus_wdata,
  output logic [7:0]              bus_rdata,
  input  logic [NUM_CH-1:0]       flags,
  input  logic [NUM_CH*CNT_W-1:0] cnt_flat,
  output logic                    run_en,
  output logic [NUM_CH-1:0]       ch_en,
  output logic [NUM_CH-1:0]       irq_en,
  output logic [NUM_CH*CNT_W-1:0] load_flat,
  output logic [NUM_CH-1:0]       load_evt,
  output logic [NUM_CH-1:0]       wipe,
  output logic [NUM_CH-1:0]       w1c
);
  localparam int HI_W = CNT_W - 8;

  logic [7:0] ofs;
  assign ofs = 8'(bus_addr);

  logic wr_ctrl, wr_kick, wr_chen, wr_ien, wr_flag;
  assign wr_ctrl = bus_wr && (ofs == OFS_CTRL);
  assign wr_kick = bus_wr && (ofs == OFS_KICK);
  assign wr_chen = bus_wr && (ofs == OFS_CHEN);
  assign wr_ien  = bus_wr && (ofs == OFS_IEN);
  assign wr_flag = bus_wr && (ofs == OFS_FLAG);

  logic [NUM_CH-1:0] wbits;
  assign wbits = bus_wdata[NUM_CH-1:0];

  // named events for the channels and the assertions
  logic run_rise, run_drop;
  assign run_rise = wr_ctrl & bus_wdata[RUN_BIT] & ~run_en;
  assign run_drop = wr_ctrl & ~bus_wdata[RUN_BIT];

  logic [NUM_CH-1:0] start_evt, kick_evt;
  assign start_evt = ({NUM_CH{wr_chen & run_en}} & wbits & ~ch_en)
                   | ({NUM_CH{run_rise}} & ch_en);
  assign kick_evt  = {NUM_CH{wr_kick & run_en}} & wbits & ch_en;
  assign load_evt  = start_evt | kick_evt;
  assign wipe      = {NUM_CH{run_drop}} | ({NUM_CH{wr_chen}} & ~wbits);
  assign w1c       = {NUM_CH{wr_flag}} & wbits;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_en <= 1'b0;
      ch_en  <= '0;
      irq_en <= '0;
    end else begin
      if (wr_ctrl) run_en <= bus_wdata[RUN_BIT];
      if (wr_chen) ch_en  <= wbits;
      if (wr_ien)  irq_en <= wbits;
    end
  end

  logic [CNT_W-1:0] load_q [NUM_CH];

  for (genvar g = 0; g < NUM_CH; g++) begin : g_load
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        load_q[g] <= '0;
      end else if (bus_wr) begin
        if (ofs == pair_hi(OFS_LOAD, g)) load_q[g][CNT_W-1:8] <= bus_wdata[HI_W-1:0];
        if (ofs == pair_lo(OFS_LOAD, g)) load_q[g][7:0]       <= bus_wdata;
      end
    end
    assign load_flat[g*CNT_W +: CNT_W] = load_q[g];
  end

  logic unused_wdata;
  assign unused_wdata = ^bus_wdata;

  always_comb begin
    bus_rdata = 8'h00;
    if (ofs == OFS_CTRL) bus_rdata[RUN_BIT]    = run_en;
    if (ofs == OFS_CHEN) bus_rdata[NUM_CH-1:0] = ch_en;
    if (ofs == OFS_IEN)  bus_rdata[NUM_CH-1:0] = irq_en;
    if (ofs == OFS_FLAG) bus_rdata[NUM_CH-1:0] = flags;
    for (int i = 0; i < NUM_CH; i++) begin
      if (ofs == pair_hi(OFS_LOAD, i))  bus_rdata = 8'(load_q[i][CNT_W-1:8]);
      if (ofs == pair_lo(OFS_LOAD, i))  bus_rdata = load_q[i][7:0];
      if (ofs == pair_hi(OFS_COUNT, i)) bus_rdata = 8'(cnt_flat[i*CNT_W+8 +: HI_W]);
      if (ofs == pair_lo(OFS_COUNT, i)) bus_rdata = cnt_flat[i*CNT_W +: 8];
    end
  end

  assert_kick_reads_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ofs == OFS_KICK) |-> bus_rdata == 8'h00);
  assert_chen_reserved_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ofs == OFS_CHEN) |-> (bus_rdata >> NUM_CH) == 8'h00);
  assert_start_only_when_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (|start_evt) |-> ((start_evt & ch_en) == '0 || run_rise));
  assert_kick_needs_run_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (|kick_evt) |-> run_en);
  assert_run_drop_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
    run_drop |=> flags == '0);
endmodule

// File: rtl/ttb_irq_merge.sv
module ttb_irq_merge #(
  parameter int NUM_CH = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] flags,
  input  logic [NUM_CH-1:0] irq_en,
  output logic              irq
);
  logic [NUM_CH-1:0] pending;
  assign pending = flags & irq_en;
  assign irq     = |pending;

  assert_irq_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (flags == '0) |-> !irq);
  assert_irq_needs_enable_R9: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (irq_en != '0));
endmodule

// File: rtl/tick_timer_bank.sv
module tick_timer_bank #(
  parameter int NUM_CH = 4,
  parameter int CNT_W  = 16,
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  output logic              irq
);
  logic                    run_en;
  logic [NUM_CH-1:0]       ch_en, irq_en, load_evt, wipe, w1c, flags, expire;
  logic [NUM_CH*CNT_W-1:0] load_flat, cnt_flat;

  ttb_regfile #(.NUM_CH(NUM_CH), .CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .flags(flags),
    .cnt_flat(cnt_flat), .run_en(run_en), .ch_en(ch_en), .irq_en(irq_en),
    .load_flat(load_flat), .load_evt(load_evt), .wipe(wipe), .w1c(w1c)
  );

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    ttb_channel #(.CNT_W(CNT_W)) u_ch (
      .clk(clk), .rst_n(rst_n), .tick(tick), .active(run_en & ch_en[g]),
      .load_evt(load_evt[g]), .wipe(wipe[g]), .w1c(w1c[g]),
      .load_val(load_flat[g*CNT_W +: CNT_W]),
      .cnt(cnt_flat[g*CNT_W +: CNT_W]), .flag(flags[g]), .expire(expire[g])
    );
  end

  ttb_irq_merge #(.NUM_CH(NUM_CH)) u_irq (
    .clk(clk), .rst_n(rst_n), .flags(flags), .irq_en(irq_en), .irq(irq)
  );

  assert_flag_needs_run_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !run_en |=> (flags == '0 || $past(run_en)));
  assert_expire_needs_tick_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (|expire) |-> tick);
endmodule

// File: tb/test_tick_timer_bank.sv
`timescale 1ns/1ps
module test_tick_timer_bank;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic       bus_wr = 1'b0;
  logic [4:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       irq;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #2 clk = ~clk;

  tick_timer_bank i_tick_timer_bank (
    .clk(clk), .rst_n(rst_n), .tick(tick), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  // reference state, built from the requirements
  bit        m_run;
  bit [3:0]  m_ce, m_ie, m_flag;
  bit [15:0] m_load [4];
  bit [15:0] m_cnt  [4];

  task automatic model_step(bit we, bit [7:0] a, bit [7:0] d, bit tk);
    bit rise, drop, ld, wp, clr, act, ex;
    rise = we && a == 8'h00 && d[7] && !m_run;
    drop = we && a == 8'h00 && !d[7];
    for (int i = 0; i < 4; i++) begin
      ld  = (we && a == 8'h02 && d[i] && !m_ce[i] && m_run) || (rise && m_ce[i]) ||
            (we && a == 8'h01 && d[i] && m_ce[i] && m_run);
      wp  = drop || (we && a == 8'h02 && !d[i]);
      clr = we && a == 8'h05 && d[i];
      act = m_run && m_ce[i];
      ex  = tk && act && !ld && m_cnt[i] == 16'd0;
      if (ld) m_cnt[i] = m_load[i];
      else if (tk && act) m_cnt[i] = (m_cnt[i] == 16'd0) ? m_load[i] : m_cnt[i] - 16'd1;
      if (wp) m_flag[i] = 1'b0;
      else if (ex) m_flag[i] = 1'b1;
      else if (clr) m_flag[i] = 1'b0;
    end
    if (we) begin
      if (a == 8'h00) m_run = d[7];
      if (a == 8'h02) m_ce = d[3:0];
      if (a == 8'h04) m_ie = d[3:0];
      if (a >= 8'h08 && a <= 8'h0f) begin
        if (a[0]) m_load[(a - 8'h08) >> 1][7:0]  = d;
        else      m_load[(a - 8'h08) >> 1][15:8] = d;
      end
    end
  endtask

  function automatic bit [7:0] exp_read(bit [7:0] a);
    if (a == 8'h00) return {m_run, 7'b0};
    if (a == 8'h02) return {4'b0, m_ce};
    if (a == 8'h04) return {4'b0, m_ie};
    if (a == 8'h05) return {4'b0, m_flag};
    if (a >= 8'h08 && a <= 8'h0f)
      return a[0] ? m_load[(a - 8'h08) >> 1][7:0] : m_load[(a - 8'h08) >> 1][15:8];
    if (a >= 8'h10 && a <= 8'h17)
      return a[0] ? m_cnt[(a - 8'h10) >> 1][7:0] : m_cnt[(a - 8'h10) >> 1][15:8];
    return 8'h00;
  endfunction

  function automatic bit exp_irq();
    return |(m_flag & m_ie);
  endfunction

  // one clock cycle with the given stimulus; returns after the edge
  task automatic cyc(bit we, bit [7:0] a, bit [7:0] d, bit tk);
    @(negedge clk);
    bus_wr = we; bus_addr = a[4:0]; bus_wdata = d; tick = tk;
    model_step(we, a, d, tk);
    @(negedge clk);
    bus_wr = 1'b0; tick = 1'b0;
  endtask

  task automatic wr(bit [7:0] a, bit [7:0] d);
    cyc(1'b1, a, d, 1'b0);
  endtask

  task automatic ticks(int n);
    for (int k = 0; k < n; k++) cyc(1'b0, 8'h00, 8'h00, 1'b1);
  endtask

  task automatic check_rd(bit [7:0] a, bit [7:0] exp, string req);
    bus_addr = a[4:0];
    #1;
    checks++;
    if (bus_rdata !== exp) begin
      failures++;
      $display("FAIL %s: read 0x%02h got 0x%02h expected 0x%02h", req, a, bus_rdata, exp);
    end
  endtask

  task automatic check_irq(bit exp, string req);
    #1;
    checks++;
    if (irq !== exp) begin
      failures++;
      $display("FAIL %s: irq got %0b expected %0b", req, irq, exp);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: run did not finish, got timeout expected completion");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    bit [7:0] addr_pool [12];
    seed = $urandom(32'h5eed1234);
    addr_pool = '{8'h00, 8'h01, 8'h02, 8'h04, 8'h05, 8'h08, 8'h09, 8'h0b,
                  8'h0d, 8'h0f, 8'h02, 8'h01};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    for (int a = 0; a < 24; a++) check_rd(8'(a), 8'h00, "R1");
    check_irq(1'b0, "R1");

    // R2: start loads the counter
    wr(8'h08, 8'h00); wr(8'h09, 8'h04);
    wr(8'h0a, 8'h01); wr(8'h0b, 8'h02);
    wr(8'h00, 8'h80); wr(8'h02, 8'h03);
    check_rd(8'h11, 8'h04, "R2");
    check_rd(8'h12, 8'h01, "R2");
    check_rd(8'h13, 8'h02, "R2");

    // R3: counting down
    ticks(2);
    check_rd(8'h11, 8'h02, "R3");
    check_rd(8'h13, 8'h00, "R3");
    check_rd(8'h12, 8'h01, "R3");

    // R10: module off freezes and clears flags
    wr(8'h00, 8'h00);
    ticks(3);
    check_rd(8'h11, 8'h02, "R10");
    check_rd(8'h05, 8'h00, "R10");

    // R11: module on reloads enabled channels
    wr(8'h00, 8'h80);
    check_rd(8'h11, 8'h04, "R11");

    // R4: expiry after reload+1 ticks
    ticks(4);
    check_rd(8'h05, 8'h00, "R4");
    check_rd(8'h11, 8'h00, "R4");
    ticks(1);
    check_rd(8'h05, 8'h01, "R4");
    check_rd(8'h11, 8'h04, "R4");

    // R9: interrupt follows enable
    check_irq(1'b0, "R9");
    wr(8'h04, 8'h01);
    check_irq(1'b1, "R9");

    // R8: write-one-to-clear
    wr(8'h05, 8'h00);
    check_rd(8'h05, 8'h01, "R8");
    wr(8'h05, 8'h01);
    check_rd(8'h05, 8'h00, "R8");
    check_irq(1'b0, "R8");

    // R5: restart strobe, and ignored on a disabled channel
    ticks(2);
    wr(8'h01, 8'hf1);
    check_rd(8'h11, 8'h04, "R5");
    wr(8'h0d, 8'h07);
    wr(8'h01, 8'h04);
    check_rd(8'h15, 8'h00, "R5");
    wr(8'h01, 8'h00);
    check_rd(8'h11, 8'h04, "R5");
    cyc(1'b1, 8'h01, 8'h01, 1'b1);
    check_rd(8'h11, 8'h04, "R5");

    // R6: read-as-zero and reserved bits
    check_rd(8'h01, 8'h00, "R6");
    wr(8'h02, 8'hf3);
    check_rd(8'h02, 8'h03, "R6");
    wr(8'h00, 8'hff);
    check_rd(8'h00, 8'h80, "R6");

    // R7: disabling a channel clears its flag
    ticks(5);
    check_rd(8'h05, 8'h01, "R7");
    wr(8'h02, 8'h02);
    check_rd(8'h05, 8'h00, "R7");

    // constrained random mix, checked against the reference state
    for (int n = 0; n < 4000; n++) begin
      bit we, tk;
      bit [7:0] a, d;
      bit [7:0] ra;
      we = ($urandom % 3) == 0;
      tk = ($urandom % 2) == 0;
      a  = addr_pool[$urandom % 12];
      d  = 8'($urandom);
      if (a == 8'h00) d[7] = ($urandom % 5) != 0;
      if (a == 8'h09 || a == 8'h0b || a == 8'h0d || a == 8'h0f) d = d & 8'h0f;
      cyc(we, a, d, tk);
      check_irq(exp_irq(), "R9");
      ra = 8'($urandom % 24);
      if (ra >= 8'h10) check_rd(ra, exp_read(ra), "R3");
      else if (ra == 8'h05) check_rd(ra, exp_read(ra), "R4");
      else check_rd(ra, exp_read(ra), "R6");
    end

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule